// File: doc/BRIEF.md
# Cache-Block Operation Decoder and Permission Gate

This block sits beside the other decoders of an instruction pipeline. It watches a 32-bit instruction word and picks out the four cache-block maintenance instructions: clean, flush, invalidate and zero. For each one it recognises, it decides whether the current privilege level may run it. Two sets of enable fields drive that decision: one set written by machine mode and one set written by supervisor mode. The block then reports the operation to perform, or an illegal-instruction indication.

An invalidate that is allowed can still be demoted to a flush. This happens when the second bit of the invalidate field does not pass the same privilege chain. Words that are not one of the four operations produce no output, so that other decoders can claim them. All results are registered, one cycle after the input strobe.

Top module: `cbo_gate`

## Requirements
- R1: A word matches when bits [6:0] = 0001111, bits [14:12] = 010 and bits [11:7] = 00000. Bits [31:20] then select the operation: 0x001 clean, 0x002 flush, 0x000 invalidate, 0x004 zero. A matched word with `inValid` high gives `outValid` high on the next cycle.
- R2: Any other value in bits [31:20], and any mismatch in the opcode, funct3 or rd field, gives `outValid` and `outIllegal` low on the next cycle.
- R3: Clean, flush and invalidate match only while `hasMgmtExt` is high. Zero matches only while `hasZeroExt` is high.
- R4: With `priv` = 11 (machine), every matched operation is legal whatever the enable fields hold.
- R5: With `priv` = 01 (supervisor), an operation is legal only when its machine enable bit is set.
- R6: With `priv` = 00 (user), an operation is legal only when its machine enable bit is set and either `hasSupMode` is low or its supervisor enable bit is set.
- R7: With `priv` = 10, every matched operation is illegal.
- R8: Clean and flush both use the `mEnCleanFlush`/`sEnCleanFlush` pair. Invalidate uses bit 0 of `mEnInval`/`sEnInval`. Zero uses `mEnZero`/`sEnZero`.
- R9: A legal invalidate is reported as invalidate when bit 1 of the invalidate fields passes the privilege chain of R4–R7. Otherwise it is reported as flush.
- R10: A matched operation that is not permitted gives `outValid` and `outIllegal` both high. `outOp` then holds the operation as decoded. `outIllegal` is never high without `outValid`.
- R11: `outOp` uses the code 0 clean, 1 flush, 2 invalidate, 3 zero. While `outValid` is high, `outRs1` equals bits [19:15] of the word. While `outValid` is low, `outOp` and `outRs1` are zero, and this includes the case where `inValid` is low.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| mEnCleanFlush | input | 1 | Machine enable for clean and flush |
| sEnCleanFlush | input | 1 | Supervisor enable for clean and flush |
| mEnInval | input | 2 | Machine invalidate field: bit 0 enable, bit 1 true-invalidate |
| sEnInval | input | 2 | Supervisor invalidate field, same layout |
| mEnZero | input | 1 | Machine enable for zero |
| sEnZero | input | 1 | Supervisor enable for zero |
| hasSupMode | input | 1 | Supervisor mode is implemented |
| hasMgmtExt | input | 1 | Clean/flush/invalidate support is present |
| hasZeroExt | input | 1 | Zero support is present |
| outValid | output | 1 | A cache-block operation was decoded |
| outOp | output | 2 | Operation code (R11) |
| outRs1 | output | 5 | Base-address register index |
| outIllegal | output | 1 | Decoded operation must raise illegal instruction |

## Verification
The assertions assume that the enable fields, privilege and feature flags are stable, known values during any cycle in which `inValid` is high. They also assume that `inValid` is low while reset is asserted. The bench drives every input only on the falling clock edge. It holds `inValid` low for the whole reset period. It draws privilege, enable and flag values from their full legal ranges, including the privilege code 10. Opcode, funct3 and rd are biased toward a match so that the permission logic is reached often.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

  typedef enum logic [1:0] {
    CBO_CLEAN = 2'd0,
    CBO_FLUSH = 2'd1,
    CBO_INVAL = 2'd2,
    CBO_ZERO  = 2'd3
  } cboOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   hit;
    logic   deny;
    cboOp_e op;
  } cboStrobe_t;

  localparam logic [1:0] PRIV_USER  = 2'b00;
  localparam logic [1:0] PRIV_SUPER = 2'b01;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

  // enable chain across machine, supervisor and user levels
  function automatic logic privPermit(input logic [1:0] priv, input logic mBit,
                                      input logic sBit, input logic hasSup);
    logic ok;
    case (priv)
      PRIV_MACH:  ok = 1'b1;
      PRIV_SUPER: ok = mBit;
      PRIV_USER:  ok = mBit && (!hasSup || sBit);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cbo_ctrl.sv
module cbo_ctrl
  import cbo_pkg::*;
#(
  parameter int OPC_W   = 7,
  parameter int FN3_W   = 3,
  parameter int RD_W    = 5,
  parameter int FN12_W  = 12
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FN3_W-1:0]  funct3,
  input  logic [RD_W-1:0]   rdIdx,
  input  logic [FN12_W-1:0] funct12,
  input  logic [1:0]        priv,
  input  logic              mEnCleanFlush,
  input  logic              sEnCleanFlush,
  input  logic [1:0]        mEnInval,
  input  logic [1:0]        sEnInval,
  input  logic              mEnZero,
  input  logic              sEnZero,
  input  logic              hasSupMode,
  input  logic              hasMgmtExt,
  input  logic              hasZeroExt,
  output cboStrobe_t        strobe
);

  localparam logic [OPC_W-1:0]  OPC_MISC_MEM = 7'b0001111;
  localparam logic [FN3_W-1:0]  FN3_CBO      = 3'b010;
  localparam logic [FN12_W-1:0] FN_INVAL     = 12'h000;
  localparam logic [FN12_W-1:0] FN_CLEAN     = 12'h001;
  localparam logic [FN12_W-1:0] FN_FLUSH     = 12'h002;
  localparam logic [FN12_W-1:0] FN_ZERO      = 12'h004;

  // chain indices: clean/flush, inval enable, inval-as-inval, zero
  localparam int CH_CF    = 0;
  localparam int CH_INV   = 1;
  localparam int CH_INVTR = 2;
  localparam int CH_ZERO  = 3;
  localparam int NUM_CH   = 4;

  logic [NUM_CH-1:0] mVec, sVec, chainOk;
  logic baseMatch, isClean, isFlush, isInval, isZero;

  assign mVec = {mEnZero, mEnInval[1], mEnInval[0], mEnCleanFlush};
  assign sVec = {sEnZero, sEnInval[1], sEnInval[0], sEnCleanFlush};

  for (genvar g = 0; g < NUM_CH; g++) begin : gChain
    assign chainOk[g] = privPermit(priv, mVec[g], sVec[g], hasSupMode);
  end

  assign baseMatch = (opcode == OPC_MISC_MEM) && (funct3 == FN3_CBO) && (rdIdx == '0);
  assign isClean   = hasMgmtExt && (funct12 == FN_CLEAN);
  assign isFlush   = hasMgmtExt && (funct12 == FN_FLUSH);
  assign isInval   = hasMgmtExt && (funct12 == FN_INVAL);
  assign isZero    = hasZeroExt && (funct12 == FN_ZERO);

  always_comb begin
    strobe.hit  = baseMatch && (isClean || isFlush || isInval || isZero);
    strobe.deny = 1'b0;
    strobe.op   = CBO_CLEAN;
    if (isClean) begin
      strobe.op   = CBO_CLEAN;
      strobe.deny = !chainOk[CH_CF];
    end else if (isFlush) begin
      strobe.op   = CBO_FLUSH;
      strobe.deny = !chainOk[CH_CF];
    end else if (isInval) begin
      strobe.deny = !chainOk[CH_INV];
      strobe.op   = (chainOk[CH_INV] && !chainOk[CH_INVTR]) ? CBO_FLUSH : CBO_INVAL;
    end else if (isZero) begin
      strobe.op   = CBO_ZERO;
      strobe.deny = !chainOk[CH_ZERO];
    end
  end

endmodule

// File: rtl/cbo_datapath.sv
module cbo_datapath
  import cbo_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [REG_IDX_W-1:0] rs1Field,
  input  cboStrobe_t           strobe,
  output logic                 outValid,
  output cboOp_e               outOp,
  output logic [REG_IDX_W-1:0] outRs1,
  output logic                 outIllegal
);

  logic take;
  assign take = inValid && strobe.hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outOp      <= CBO_CLEAN;
      outRs1     <= '0;
    end else begin
      outValid   <= take;
      outIllegal <= take && strobe.deny;
      outOp      <= take ? strobe.op : CBO_CLEAN;
      outRs1     <= take ? rs1Field : '0;
    end
  end

  // R10
  illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> outValid);

  // R11
  rs1_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.hit) |=> (outRs1 == $past(rs1Field)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outOp == CBO_CLEAN && outRs1 == '0));

endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
  import cbo_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [1:0]           priv,
  input  logic                 mEnCleanFlush,
  input  logic                 sEnCleanFlush,
  input  logic [1:0]           mEnInval,
  input  logic [1:0]           sEnInval,
  input  logic                 mEnZero,
  input  logic                 sEnZero,
  input  logic                 hasSupMode,
  input  logic                 hasMgmtExt,
  input  logic                 hasZeroExt,
  output logic                 outValid,
  output logic [1:0]           outOp,
  output logic [REG_IDX_W-1:0] outRs1,
  output logic                 outIllegal
);

  localparam int OPC_W    = 7;
  localparam int FN3_W    = 3;
  localparam int RD_LSB   = OPC_W;
  localparam int FN3_LSB  = RD_LSB + REG_IDX_W;
  localparam int RS1_LSB  = FN3_LSB + FN3_W;
  localparam int FN12_LSB = RS1_LSB + REG_IDX_W;
  localparam int FN12_W   = INSTR_W - FN12_LSB;

  cboStrobe_t strobe;
  cboOp_e     opReg;

  cbo_ctrl #(
    .OPC_W(OPC_W), .FN3_W(FN3_W), .RD_W(REG_IDX_W), .FN12_W(FN12_W)
  ) uCtrl (
    .opcode       (instr[OPC_W-1:0]),
    .funct3       (instr[FN3_LSB +: FN3_W]),
    .rdIdx        (instr[RD_LSB +: REG_IDX_W]),
    .funct12      (instr[FN12_LSB +: FN12_W]),
    .priv         (priv),
    .mEnCleanFlush(mEnCleanFlush),
    .sEnCleanFlush(sEnCleanFlush),
    .mEnInval     (mEnInval),
    .sEnInval     (sEnInval),
    .mEnZero      (mEnZero),
    .sEnZero      (sEnZero),
    .hasSupMode   (hasSupMode),
    .hasMgmtExt   (hasMgmtExt),
    .hasZeroExt   (hasZeroExt),
    .strobe       (strobe)
  );

  cbo_datapath #(.REG_IDX_W(REG_IDX_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .rs1Field  (instr[RS1_LSB +: REG_IDX_W]),
    .strobe    (strobe),
    .outValid  (outValid),
    .outOp     (opReg),
    .outRs1    (outRs1),
    .outIllegal(outIllegal)
  );

  assign outOp = opReg;

  // R4
  machine_never_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && priv == PRIV_MACH) |=> !outIllegal);

  // R7
  reserved_priv_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.hit && priv == 2'b10) |=> (outValid && outIllegal));

  // R2
  unlisted_funct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(instr[FN12_LSB +: FN12_W] inside {12'h000, 12'h001, 12'h002, 12'h004}))
      |=> (!outValid && !outIllegal));

  // R3
  zero_ext_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !hasZeroExt && instr[FN12_LSB +: FN12_W] == 12'h004) |=> !outValid);

  // R9
  zero_keeps_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.hit && instr[FN12_LSB +: FN12_W] == 12'h004) |=> (outOp == 2'd3));

endmodule

// File: tb/tb_cbo_gate.sv
`timescale 1ns/1ps
module tb_cbo_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  priv = 2'b11;
  logic        mEnCleanFlush = 1'b0, sEnCleanFlush = 1'b0;
  logic [1:0]  mEnInval = '0, sEnInval = '0;
  logic        mEnZero = 1'b0, sEnZero = 1'b0;
  logic        hasSupMode = 1'b1, hasMgmtExt = 1'b1, hasZeroExt = 1'b1;
  logic        outValid, outIllegal;
  logic [1:0]  outOp;
  logic [4:0]  outRs1;

  always #4 clk = ~clk;

  cbo_gate dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .priv(priv),
    .mEnCleanFlush(mEnCleanFlush), .sEnCleanFlush(sEnCleanFlush),
    .mEnInval(mEnInval), .sEnInval(sEnInval), .mEnZero(mEnZero), .sEnZero(sEnZero),
    .hasSupMode(hasSupMode), .hasMgmtExt(hasMgmtExt), .hasZeroExt(hasZeroExt),
    .outValid(outValid), .outOp(outOp), .outRs1(outRs1), .outIllegal(outIllegal)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  bit    pending = 0;
  int    expValid, expOp, expRs1, expIll;
  string pendTag;

  function automatic int allow(int p, int m, int s, int sup);
    if (p == 3) return 1;
    if (p == 1) return m;
    if (p == 0) return (m != 0 && (sup == 0 || s != 0)) ? 1 : 0;
    return 0;
  endfunction

  // behavioural reference; op codes 0 clean,1 flush,2 inval,3 zero
  task automatic predict();
    int f12, p, sup, kind, ok;
    f12 = int'(instr[31:20]);
    p = int'(priv);
    sup = int'(hasSupMode);
    kind = -1;
    if (inValid && instr[6:0] == 7'h0F && instr[14:12] == 3'd2 && instr[11:7] == 5'd0) begin
      if (hasMgmtExt && f12 == 1) kind = 0;
      else if (hasMgmtExt && f12 == 2) kind = 1;
      else if (hasMgmtExt && f12 == 0) kind = 2;
      else if (hasZeroExt && f12 == 4) kind = 3;
    end
    if (kind < 0) begin
      expValid = 0; expOp = 0; expRs1 = 0; expIll = 0;
    end else begin
      expValid = 1;
      expRs1 = int'(instr[19:15]);
      expOp = kind;
      case (kind)
        0, 1: ok = allow(p, mEnCleanFlush, sEnCleanFlush, sup);
        2:    ok = allow(p, mEnInval[0], sEnInval[0], sup);
        default: ok = allow(p, mEnZero, sEnZero, sup);
      endcase
      expIll = ok ? 0 : 1;
      if (kind == 2 && ok != 0 && allow(p, mEnInval[1], sEnInval[1], sup) == 0) expOp = 1;
    end
  endtask

  task automatic compare(string tag);
    nChecks++;
    if (int'(outValid) != expValid || int'(outOp) != expOp ||
        int'(outRs1) != expRs1 || int'(outIllegal) != expIll) begin
      nFails++;
      $display("FAIL %s: got v=%0d op=%0d rs1=%0d ill=%0d, expected v=%0d op=%0d rs1=%0d ill=%0d",
               tag, outValid, outOp, outRs1, outIllegal, expValid, expOp, expRs1, expIll);
    end
  endtask

  function automatic logic [31:0] mk(logic [11:0] f, logic [4:0] rs);
    return {f, rs, 3'b010, 5'b00000, 7'b0001111};
  endfunction

  task automatic push(logic iv, logic [31:0] ins, logic [1:0] pr, logic [1:0] cf,
                      logic [3:0] inv4, logic [1:0] zr, logic sup, logic mg, logic zx,
                      string tag);
    @(negedge clk);
    if (pending) compare(pendTag);
    inValid = iv; instr = ins; priv = pr;
    mEnCleanFlush = cf[1]; sEnCleanFlush = cf[0];
    mEnInval = inv4[3:2]; sEnInval = inv4[1:0];
    mEnZero = zr[1]; sEnZero = zr[0];
    hasSupMode = sup; hasMgmtExt = mg; hasZeroExt = zx;
    predict();
    pendTag = tag;
    pending = 1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    expValid = 0; expOp = 0; expRs1 = 0; expIll = 0;
    compare("R12 reset");
    rstN = 1'b1;

    push(1, mk(12'h001, 5'd7), 2'b11, 2'b00, 4'h0, 2'b00, 1, 1, 1, "R1 clean machine");
    push(1, mk(12'h004, 5'd31), 2'b11, 2'b00, 4'h0, 2'b00, 1, 1, 1, "R1 zero machine");
    push(1, mk(12'h000, 5'd3), 2'b11, 2'b00, 4'h0, 2'b00, 1, 1, 1, "R4 inval machine no enables");
    push(1, mk(12'h001, 5'd4), 2'b01, 2'b01, 4'h0, 2'b00, 1, 1, 1, "R5 super clean m=0");
    push(1, mk(12'h002, 5'd4), 2'b01, 2'b10, 4'h0, 2'b00, 1, 1, 1, "R5 super flush m=1");
    push(1, mk(12'h002, 5'd9), 2'b00, 2'b10, 4'h0, 2'b00, 1, 1, 1, "R6 user s=0 sup present");
    push(1, mk(12'h002, 5'd9), 2'b00, 2'b10, 4'h0, 2'b00, 0, 1, 1, "R6 user no supervisor mode");
    push(1, mk(12'h004, 5'd9), 2'b00, 2'b00, 4'h0, 2'b11, 1, 1, 1, "R6 user zero both set");
    push(1, mk(12'h004, 5'd1), 2'b10, 2'b11, 4'hF, 2'b11, 1, 1, 1, "R7 reserved priv");
    push(1, mk(12'h004, 5'd2), 2'b01, 2'b10, 4'hF, 2'b00, 1, 1, 1, "R8 zero own field");
    push(1, mk(12'h001, 5'd2), 2'b01, 2'b00, 4'hF, 2'b11, 1, 1, 1, "R8 clean own field");
    push(1, mk(12'h000, 5'd5), 2'b01, 2'b00, 4'h4, 2'b00, 1, 1, 1, "R9 inval demoted to flush");
    push(1, mk(12'h000, 5'd5), 2'b01, 2'b00, 4'hC, 2'b00, 1, 1, 1, "R9 true inval");
    push(1, mk(12'h000, 5'd6), 2'b00, 2'b00, 4'hD, 2'b00, 1, 1, 1, "R9 user inval s bit1 clear");
    push(1, mk(12'h000, 5'd6), 2'b01, 2'b11, 4'h8, 2'b11, 1, 1, 1, "R10 denied inval keeps op");
    push(1, mk(12'h001, 5'd8), 2'b11, 2'b11, 4'hF, 2'b11, 1, 0, 1, "R3 mgmt absent");
    push(1, mk(12'h004, 5'd8), 2'b11, 2'b11, 4'hF, 2'b11, 1, 1, 0, "R3 zero absent");
    push(1, mk(12'h003, 5'd8), 2'b11, 2'b11, 4'hF, 2'b11, 1, 1, 1, "R2 unlisted funct");
    push(1, mk(12'h001, 5'd8) | 32'h0000_0080, 2'b11, 2'b11, 4'hF, 2'b11, 1, 1, 1, "R2 rd nonzero");
    push(1, mk(12'h001, 5'd8) ^ 32'h0000_2000, 2'b11, 2'b11, 4'hF, 2'b11, 1, 1, 1, "R2 funct3 wrong");
    push(0, mk(12'h002, 5'd8), 2'b11, 2'b11, 4'hF, 2'b11, 1, 1, 1, "R11 no input strobe");

    for (int i = 0; i < 600; i++) begin
      logic [11:0] f;
      logic [31:0] w;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: f = 12'h000; 1: f = 12'h001; 2: f = 12'h002; 3: f = 12'h004;
        default: f = 12'($urandom);
      endcase
      w = mk(f, 5'($urandom));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(0, 14));
      push(1'($urandom_range(0, 5) != 0), w, 2'($urandom), 2'($urandom), 4'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom_range(0, 4) != 0),
           1'($urandom_range(0, 4) != 0), "R1/R4-R11 random vector");
    end

    push(0, '0, 2'b11, 2'b00, 4'h0, 2'b00, 1, 1, 1, "R11 idle");
    @(negedge clk);
    compare(pendTag);
    finishRun();
  end

endmodule